// File: doc/BRIEF.md
# Dual-Channel PWM Slice

This block produces two pulse-width-modulated outputs from a single counter. A programmable limit value sets the length of one counting cycle. Each of the two channels holds a threshold of its own and drives its pin high while the counter sits below that threshold. As a result, the two channels share one period and can have independent duty cycles.

Two counting modes are available. In the sawtooth mode the counter climbs from zero to the limit and then restarts at zero. The period is limit+1 cycles, and the rising edges of both pins coincide at each restart. In the centred mode the counter climbs to the limit and then descends back to zero without repeating either end point. The period is 2×limit cycles, and each pulse sits symmetrically around count zero whatever its width.

A threshold of zero gives a pin that never rises. A threshold of limit+1 gives a pin that never falls, so the 0% and 100% duty ends carry no edges at all. Software writes new limit and threshold values into a shadow bank. The running copies change only at the instant the counter returns to zero, so a period is never cut short or stretched by a write.

The counter is a two-state machine:
- **ST_RISE** counts upward. It takes the transition *peak* to ST_FALL when it reaches the limit in centred mode, provided the limit is 2 or more.
- **ST_FALL** counts downward. It takes the transition *floor* back to ST_RISE when the next count would be zero, or at once if centred mode has been switched off.
- The *wrap* transition keeps the machine in ST_RISE and resets the count to zero at the limit. This happens in sawtooth mode, and in centred mode when the limit is 0 or 1.
- *Wrap* and *floor* are the period boundaries at which the shadow bank is copied into the running registers.
- While the run bit is clear, the machine holds both its state and its count.

Top module: `pwm_pair_slice`

## Requirements
- R1: A synchronous reset clears the counter, the direction state and every register (shadow, running and control) to 0, and both pins are low during and after it.
- R2: In sawtooth mode (control bit1 = 0) the counter runs 0,1,…,limit and then 0 again, so the period is limit+1 cycles. Each pin with 0 < threshold ≤ limit rises exactly once per period.
- R3: A pin is high exactly while run is set and the count is below that channel's running threshold, so in sawtooth mode it is high for `threshold` cycles of every limit+1.
- R4: In sawtooth mode, whenever both channels have a threshold strictly between 0 and limit+1, the two pins rise on the same cycle.
- R5: In centred mode (control bit1 = 1, limit ≥ 1) the counter runs 0,1,…,limit,limit−1,…,1 with a period of 2×limit cycles. A pin with 1 ≤ threshold ≤ limit is high for 2×threshold−1 cycles per period, centred on count 0.
- R6: A threshold of 0 keeps its pin low with no edge in either mode.
- R7: A threshold of limit+1 or more keeps its pin high with no edge while running, in either mode.
- R8: Writes to the limit and threshold registers land in a shadow bank. The running copies change only when the counter returns to zero at a period boundary, so the current period completes with the old values.
- R9: When the run bit is clear, the counter and direction hold their values and both pins are low. Setting run again resumes the count from where it stopped.
- R10: Register selects on `wr_sel` are 0 = limit, 1 = channel A threshold, 2 = channel B threshold, 3 = control. Control bit0 is run and bit1 is centred mode, and control takes effect on the clock edge of the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 limit, 1 threshold A, 2 threshold B, 3 control) |
| wr_data | input | W | Write data |
| pwm_a | output | 1 | Channel A pulse output |
| pwm_b | output | 1 | Channel B pulse output |

## Verification
The assertions rely on a few conditions at the inputs:
- Reset is applied before the first write.
- The limit changes only through the shadow bank, which keeps the count at or below the running limit at every cycle.
- The edge-alignment property assumes sawtooth mode was in force on the previous cycle and that run did not just rise.

The stimulus meets these conditions as follows:
- It resets the block before every configuration.
- It draws random limits from 1 to 40 and thresholds only from 0 to limit+1.
- It includes the directed cases limit=3 and limit=254.
- The only changes it makes while running are one threshold rewrite mid-period and one run pause.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_LIMIT = 2'd0;
    localparam logic [SEL_W-1:0] SEL_THR_A = 2'd1;
    localparam logic [SEL_W-1:0] SEL_THR_B = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd3;

    localparam int CTRL_RUN_BIT    = 0;
    localparam int CTRL_CENTRE_BIT = 1;

    localparam int NUM_CH = 2;

    typedef enum logic [0:0] {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } cnt_state_t;

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_pair_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [W-1:0]              wr_data,
    input  logic                      load,
    output logic [W-1:0]              limit_act,
    output logic [NUM_CH-1:0][W-1:0]  thr_act,
    output logic                      run,
    output logic                      centre
);

    logic [W-1:0]             limit_sh;
    logic [NUM_CH-1:0][W-1:0] thr_sh;

    // Shadow side and control: written straight from the port.
    always_ff @(posedge clk) begin
        if (rst) begin
            limit_sh <= '0;
            thr_sh   <= '0;
            run      <= 1'b0;
            centre   <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_LIMIT: limit_sh  <= wr_data;
                SEL_THR_A: thr_sh[0] <= wr_data;
                SEL_THR_B: thr_sh[1] <= wr_data;
                SEL_CTRL: begin
                    run    <= wr_data[CTRL_RUN_BIT];
                    centre <= wr_data[CTRL_CENTRE_BIT];
                end
                default: ;
            endcase
        end
    end

    // Running side: copied only at a period boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            limit_act <= '0;
            thr_act   <= '0;
        end else if (load) begin
            limit_act <= limit_sh;
            thr_act   <= thr_sh;
        end
    end

endmodule

// File: rtl/pwm_count_fsm.sv
module pwm_count_fsm
    import pwm_pair_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         centre,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output cnt_state_t   st,
    output logic         load
);

    localparam logic [W-1:0] ONE = W'(1);

    cnt_state_t   st_n;
    logic [W-1:0] cnt_n;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_RISE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // Next state, next count and boundary strobe.
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        load  = 1'b0;
        if (run) begin
            unique case (st)
                ST_RISE: begin
                    if (cnt >= limit) begin
                        if (!centre || limit <= ONE) begin
                            cnt_n = '0;            // wrap
                            load  = 1'b1;
                        end else begin
                            cnt_n = limit - ONE;   // peak
                            st_n  = ST_FALL;
                        end
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
                ST_FALL: begin
                    if (!centre || cnt <= ONE) begin
                        cnt_n = '0;                // floor
                        st_n  = ST_RISE;
                        load  = 1'b1;
                    end else begin
                        cnt_n = cnt - ONE;
                    end
                end
                default: begin
                    cnt_n = '0;
                    st_n  = ST_RISE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
    parameter int W = 16
) (
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] thr,
    output logic         pin
);

    always_comb begin
        pin = run && (cnt < thr);
    end

endmodule

// File: rtl/pwm_pair_slice.sv
module pwm_pair_slice
    import pwm_pair_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    output logic             pwm_a,
    output logic             pwm_b
);

    logic [W-1:0]             limit_act;
    logic [NUM_CH-1:0][W-1:0] thr_act;
    logic                     run;
    logic                     centre;
    logic                     load;
    logic [W-1:0]             cnt;
    cnt_state_t               st;
    logic [NUM_CH-1:0]        pins;

    pwm_shadow_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .load      (load),
        .limit_act (limit_act),
        .thr_act   (thr_act),
        .run       (run),
        .centre    (centre)
    );

    pwm_count_fsm #(.W(W)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .centre (centre),
        .limit  (limit_act),
        .cnt    (cnt),
        .st     (st),
        .load   (load)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm_cmp_chan #(.W(W)) u_chan (
            .run (run),
            .cnt (cnt),
            .thr (thr_act[g]),
            .pin (pins[g])
        );
    end

    always_comb begin
        pwm_a = pins[0];
        pwm_b = pins[1];
    end

endmodule

// File: rtl/pwm_pair_checker.sv
module pwm_pair_checker
    import pwm_pair_pkg::*;
#(
    parameter int W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     run,
    input logic                     centre,
    input logic [W-1:0]             cnt,
    input logic [W-1:0]             limit_act,
    input logic [NUM_CH-1:0][W-1:0] thr_act,
    input cnt_state_t               st,
    input logic                     pwm_a,
    input logic                     pwm_b
);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit_act); // R2

    AST_ZERO_THR_LOW: assert property (@(posedge clk) disable iff (rst)
        (thr_act[0] == '0) |-> !pwm_a); // R6

    AST_FULL_THR_HIGH: assert property (@(posedge clk) disable iff (rst)
        (run && thr_act[1] > limit_act) |-> pwm_b); // R7

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!pwm_a && !pwm_b)); // R9

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(cnt) && $stable(st))); // R9

    AST_SAW_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwm_a) && $past(run) && !$past(centre)) |-> (cnt == '0)); // R4

    AST_FALL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FALL) |-> (cnt != '0)); // R5

    AST_LIMIT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$stable(limit_act) |-> (cnt == '0)); // R8

endmodule

bind pwm_pair_slice pwm_pair_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .centre    (centre),
    .cnt       (cnt),
    .limit_act (limit_act),
    .thr_act   (thr_act),
    .st        (st),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b)
);

// File: tb/pwm_pair_slice_bench.sv
module pwm_pair_slice_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int K = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_a;
    logic         pwm_b;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_pair_slice #(.W(W)) u_pwm_pair_slice (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pwm_a   (pwm_a),
        .pwm_b   (pwm_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int lim, input bit cen);
        if (cen) return (lim <= 0) ? 1 : 2 * lim;
        return lim + 1;
    endfunction

    function automatic int exp_high(input int lim, input int thr, input bit cen);
        int p = exp_period(lim, cen);
        if (thr == 0) return 0;
        if (thr > lim) return p;
        return cen ? (2 * thr - 1) : thr;
    endfunction

    task automatic wr(input logic [1:0] sel, input int val);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic configure(input int lim, input int ta, input int tb, input bit cen);
        do_reset();
        wr(2'd0, lim);
        wr(2'd1, ta);
        wr(2'd2, tb);
        wr(2'd3, {30'd0, cen, 1'b1});
    endtask

    task automatic run_case(input int lim, input int ta, input int tb, input bit cen);
        int p = exp_period(lim, cen);
        int ha = 0, hb = 0, ra = 0, rb = 0, mis = 0;
        int ea = exp_high(lim, ta, cen);
        int eb = exp_high(lim, tb, cen);
        logic pa, pb;
        string rq;
        configure(lim, ta, tb, cen);
        repeat (2 * p + 2) @(negedge clk);
        pa = pwm_a;
        pb = pwm_b;
        for (int i = 0; i < K * p; i++) begin
            @(negedge clk);
            if (pwm_a) ha++;
            if (pwm_b) hb++;
            if (pwm_a && !pa) ra++;
            if (pwm_b && !pb) rb++;
            if ((pwm_a && !pa) != (pwm_b && !pb)) mis++;
            pa = pwm_a;
            pb = pwm_b;
        end
        rq = cen ? "R5" : "R3";
        if (ta == 0) rq = "R6";
        else if (ta > lim) rq = "R7";
        chk({rq, " high A"}, ha, K * ea);
        chk({cen ? "R5" : "R2", " rises A"}, ra, (ea > 0 && ea < p) ? K : 0);
        rq = cen ? "R5" : "R3";
        if (tb == 0) rq = "R6";
        else if (tb > lim) rq = "R7";
        chk({rq, " high B"}, hb, K * eb);
        chk({cen ? "R5" : "R2", " rises B"}, rb, (eb > 0 && eb < p) ? K : 0);
        if (!cen && ea > 0 && ea < p && eb > 0 && eb < p)
            chk("R4 misaligned rises", mis, 0);
    endtask

    task automatic wait_rise_a();
        logic pa = pwm_a;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (pwm_a && !pa) return;
            pa = pwm_a;
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4021);

        // R1: reset state
        @(negedge clk);
        chk("R1 pwm_a in reset", int'(pwm_a), 0);
        chk("R1 pwm_b in reset", int'(pwm_b), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 pwm_a after reset", int'(pwm_a), 0);
        chk("R1 pwm_b after reset", int'(pwm_b), 0);
        // R10: run with zero registers still yields low outputs
        wr(2'd3, 1);
        repeat (4) @(negedge clk);
        chk("R10 run with zero thresholds", int'(pwm_a | pwm_b), 0);

        // Directed cases
        run_case(3, 1, 3, 1'b0);
        run_case(254, 0, 255, 1'b0);
        run_case(254, 127, 1, 1'b0);
        run_case(5, 0, 6, 1'b1);
        run_case(5, 2, 5, 1'b1);
        run_case(1, 1, 2, 1'b1);
        run_case(7, 8, 0, 1'b0);

        // R8: mid-period rewrite waits for the boundary (limit 9, A=5)
        configure(9, 5, 5, 1'b0);
        repeat (25) @(negedge clk);
        wait_rise_a();              // count is 0 here
        wr(2'd1, 1);                // count 2 on return
        for (int i = 0; i < 3; i++) begin
            chk("R8 old threshold kept", int'(pwm_a), 1);
            @(negedge clk);
        end
        chk("R8 old threshold falls at 5", int'(pwm_a), 0);
        repeat (5) @(negedge clk);  // count 0 of next period
        chk("R8 new threshold high at 0", int'(pwm_a), 1);
        @(negedge clk);
        chk("R8 new threshold low at 1", int'(pwm_a), 0);

        // R9: pause holds the count (limit 9, A=5)
        configure(9, 5, 5, 1'b0);
        repeat (25) @(negedge clk);
        wait_rise_a();
        wr(2'd3, 0);                // count frozen at 2
        for (int i = 0; i < 5; i++) begin
            chk("R9 low while stopped", int'(pwm_a | pwm_b), 0);
            @(negedge clk);
        end
        wr(2'd3, 1);
        for (int i = 0; i < 3; i++) begin
            chk("R9 resume from held count", int'(pwm_a), 1);
            @(negedge clk);
        end
        chk("R9 resume falls at 5", int'(pwm_a), 0);

        // Constrained random cases
        for (int n = 0; n < 16; n++) begin
            int lim = 1 + int'($urandom_range(39));
            int ta = int'($urandom_range(lim + 1));
            int tb = int'($urandom_range(lim + 1));
            bit cen = bit'($urandom_range(1));
            run_case(lim, ta, tb, cen);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule